// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges seven reset requests into a single system reset. The requests are an active-low external reset pin, a watchdog overflow, a power-on detector, a low-voltage detector, an illegal-opcode detector, a RAM parity error and an illegal memory access. Each asynchronous request passes through a two-flop synchronizer. The external pin is also run through a low-time filter, so that short glitches on the board cannot reset the chip. The power-on detector asserts the reset output at once, with no clock needed. Every other source asserts it on a reference-clock edge. Release always happens on a clock edge, a fixed number of cycles after the last active request.

While reset is held, the block switches all oscillator enables off. It also steers the default pad states, and one pad depends on which kind of reset is in progress. In the first cycle after release it pulses a strobe that tells the CPU to load its start address from the two vector bytes. A small sticky register records which internal sources have caused resets since the last hard reset. Software can clear this register with a strobe.

Top module: `reset_hub`

## Requirements
- R1: Holding `wdtOvf`, `lvdDet`, `ramParityErr` or `illegalAccess` high for at least one reference-clock cycle drives `sysRstN` low.
- R2: The external pin counts only after it has been seen low for at least FILT_CYC consecutive synchronized cycles, where FILT_CYC = REF_CLK_KHZ*10/1000 (that is, 10 µs). A low pulse of FILT_CYC-1 cycles or fewer leaves `sysRstN`, `bootFetch` and `causes` untouched.
- R3: A cycle with `opcodeValid` high and `opcodeByte` equal to 8'hFF requests reset. Any other byte value does not.
- R4: While `debugMode` is high, the illegal-opcode request is suppressed: there is no reset and `causes[2]` is not set.
- R5: `sysRstN` rises at the STRETCH-th clock edge after the last edge at which a request was present. A request present at N consecutive edges therefore gives a low time of N+STRETCH-1 cycles.
- R6: `bootFetch` is high for exactly one cycle, namely the first cycle in which `sysRstN` is high. `bootVecLo` is 16'h0000 and `bootVecHi` is 16'h0001, the low-byte and high-byte vector locations.
- R7: `oscEn` is all zeros while `sysRstN` is low and all ones while it is high.
- R8: `padAPullEn` is 0 (pad high-impedance) during a reset caused by the external pin or by power-on. It is 1 (pulled high) during any other reset and whenever `sysRstN` is high.
- R9: `padBDriveLow` is 1 at all times, during and after reset. `otherPadOe` is all zeros.
- R10: `causes` bit 0 is the watchdog, bit 1 low voltage, bit 2 illegal opcode, bit 3 RAM parity and bit 4 illegal access. Bits are sticky and accumulate across resets. A `causeReadClear` pulse clears every bit that is not being set in that same cycle.
- R11: A filtered external reset clears all `causes` bits. While `porDet` is high, `causes` reads 0 immediately and `sysRstN` is low, whatever the clock is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| porDet | input | 1 | Power-on detector output, active high, asynchronous |
| extRstN | input | 1 | External reset pin, active low, asynchronous |
| wdtOvf | input | 1 | Watchdog overflow request |
| lvdDet | input | 1 | Low-voltage detector request |
| ramParityErr | input | 1 | RAM parity error request |
| illegalAccess | input | 1 | Illegal memory access request |
| opcodeValid | input | 1 | CPU is executing the byte on opcodeByte |
| opcodeByte | input | 8 | Opcode byte under execution |
| debugMode | input | 1 | Debug/emulation active; suppresses the illegal-opcode reset |
| causeReadClear | input | 1 | Software strobe that clears the cause register |
| sysRstN | output | 1 | System reset, active low |
| bootFetch | output | 1 | One-cycle pulse telling the CPU to load the start vector |
| bootVecLo | output | 16 | Address of the vector low byte |
| bootVecHi | output | 16 | Address of the vector high byte |
| oscEn | output | NUM_OSC | Oscillator enables, all off during reset |
| padAPullEn | output | 1 | Pull-up pad: 1 pulled high, 0 high-impedance |
| padBDriveLow | output | 1 | Second pad driven low |
| otherPadOe | output | NUM_PADS | Output enables of the remaining pads |
| causes | output | 5 | Sticky record of internal reset sources |

## Verification
External pin pulses are drawn at random lengths between one cycle and twice the filter length, with the two lengths on either side of the threshold also driven directly. These pulses separate a filter that counts one cycle short or long from a correct one, and show that a filtered reset both clears `causes` and floats the pull-up pad. Single-source pulses of each internal kind are interleaved with them. Against the exact low time, these show the release stretch and the per-source cause bit, and they show that the pull-up pad stays driven for soft resets. Opcode cycles mix the value 8'hFF with other values and with debug mode on or off, which isolates the opcode compare and its suppression. Read-clear strobes and a power-on pulse in mid-run show that the sticky record empties only through these paths.

// File: rtl/reset_hub_pkg.sv
package reset_hub_pkg;

  localparam int NUM_CAUSE = 5;
  localparam int CAUSE_WDT = 0;
  localparam int CAUSE_LVD = 1;
  localparam int CAUSE_OPC = 2;
  localparam int CAUSE_PAR = 3;
  localparam int CAUSE_ACC = 4;

  localparam logic [7:0] ILLEGAL_OPC = 8'hFF;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_CAUSE-1:0] setCause;  // internal sources seen this cycle
    logic                 hardEvt;   // filtered external pin request
    logic                 rstActive; // reset currently held
  } hubStrobe_t;

endpackage

// File: rtl/reset_hub_sync.sv
module reset_hub_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta;
    logic hold;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta <= RST_VAL[i];
        hold <= RST_VAL[i];
      end else begin
        meta <= d[i];
        hold <= meta;
      end
    end
    assign q[i] = hold;
  end

endmodule

// File: rtl/reset_hub_ctrl.sv
module reset_hub_ctrl
  import reset_hub_pkg::*;
#(
  parameter int FILT_CYC = 320,
  parameter int STRETCH  = 16
) (
  input  logic       clk,
  input  logic       porDet,
  input  logic       extRstN,
  input  logic       wdtOvf,
  input  logic       lvdDet,
  input  logic       ramParityErr,
  input  logic       illegalAccess,
  input  logic       opcodeValid,
  input  logic [7:0] opcodeByte,
  input  logic       debugMode,
  output logic       coreRstN,
  output logic       sysRstN,
  output logic       bootFetch,
  output hubStrobe_t strobe
);

  localparam int FW = $clog2(FILT_CYC + 1);
  localparam int SW = $clog2(STRETCH + 1);

  // power-on: assert at once, release on the clock
  logic [1:0] porPipe;
  always_ff @(posedge clk or posedge porDet) begin
    if (porDet) porPipe <= '0;
    else        porPipe <= {porPipe[0], 1'b1};
  end
  assign coreRstN = porPipe[1];

  logic pinS, accS, parS, lvdS, wdtS;
  reset_hub_sync #(.W(5), .RST_VAL(5'b10000)) u_sync (
    .clk  (clk),
    .rstN (coreRstN),
    .d    ({extRstN, illegalAccess, ramParityErr, lvdDet, wdtOvf}),
    .q    ({pinS, accS, parS, lvdS, wdtS})
  );

  // low-time filter on the external pin
  logic [FW-1:0] lowCnt;
  logic          extFilt;
  always_ff @(posedge clk or negedge coreRstN) begin
    if (!coreRstN)                   lowCnt <= '0;
    else if (pinS)                   lowCnt <= '0;
    else if (lowCnt != FW'(FILT_CYC)) lowCnt <= lowCnt + 1'b1;
  end
  assign extFilt = (lowCnt == FW'(FILT_CYC));

  // illegal opcode detect
  logic opcReq;
  always_ff @(posedge clk or negedge coreRstN) begin
    if (!coreRstN) opcReq <= 1'b0;
    else           opcReq <= opcodeValid && (opcodeByte == ILLEGAL_OPC) && !debugMode;
  end

  logic [NUM_CAUSE-1:0] srcVec;
  always_comb begin
    srcVec            = '0;
    srcVec[CAUSE_WDT] = wdtS;
    srcVec[CAUSE_LVD] = lvdS;
    srcVec[CAUSE_OPC] = opcReq;
    srcVec[CAUSE_PAR] = parS;
    srcVec[CAUSE_ACC] = accS;
  end

  logic anyReq;
  assign anyReq = extFilt | (|srcVec);

  // hold / stretch sequencer
  logic          active;
  logic [SW-1:0] holdCnt;
  always_ff @(posedge clk or negedge coreRstN) begin
    if (!coreRstN) begin
      active    <= 1'b1;
      holdCnt   <= '0;
      bootFetch <= 1'b0;
    end else begin
      bootFetch <= 1'b0;
      if (anyReq) begin
        active  <= 1'b1;
        holdCnt <= '0;
      end else if (active) begin
        if (holdCnt == SW'(STRETCH - 1)) begin
          active    <= 1'b0;
          bootFetch <= 1'b1;
        end else begin
          holdCnt <= holdCnt + 1'b1;
        end
      end
    end
  end

  assign sysRstN          = ~active;
  assign strobe.setCause  = srcVec;
  assign strobe.hardEvt   = extFilt;
  assign strobe.rstActive = active;

endmodule

// File: rtl/reset_hub_dp.sv
module reset_hub_dp
  import reset_hub_pkg::*;
#(
  parameter int NUM_OSC = 4
) (
  input  logic                 clk,
  input  logic                 coreRstN,
  input  logic                 causeReadClear,
  input  hubStrobe_t           strobe,
  output logic [NUM_OSC-1:0]   oscEn,
  output logic                 padAPullEn,
  output logic [NUM_CAUSE-1:0] causes
);

  logic [NUM_CAUSE-1:0] causeReg;
  logic                 hardKind;

  always_ff @(posedge clk or negedge coreRstN) begin
    if (!coreRstN)          causeReg <= '0;
    else if (strobe.hardEvt) causeReg <= '0;
    else                    causeReg <= (causeReg & ~{NUM_CAUSE{causeReadClear}}) | strobe.setCause;
  end

  // kind of the reset in progress: hard (pin / power-on) or soft
  always_ff @(posedge clk or negedge coreRstN) begin
    if (!coreRstN)                                     hardKind <= 1'b1;
    else if (strobe.hardEvt)                           hardKind <= 1'b1;
    else if ((|strobe.setCause) && !strobe.rstActive)  hardKind <= 1'b0;
  end

  assign oscEn      = {NUM_OSC{~strobe.rstActive}};
  assign padAPullEn = ~(strobe.rstActive & hardKind);
  assign causes     = causeReg;

endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import reset_hub_pkg::*;
#(
  parameter int REF_CLK_KHZ = 32000,
  parameter int STRETCH     = 16,
  parameter int NUM_OSC     = 4,
  parameter int NUM_PADS    = 8,
  parameter int AW          = 16,
  parameter int VEC_LO_ADDR = 0
) (
  input  logic                 clk,
  input  logic                 porDet,
  input  logic                 extRstN,
  input  logic                 wdtOvf,
  input  logic                 lvdDet,
  input  logic                 ramParityErr,
  input  logic                 illegalAccess,
  input  logic                 opcodeValid,
  input  logic [7:0]           opcodeByte,
  input  logic                 debugMode,
  input  logic                 causeReadClear,
  output logic                 sysRstN,
  output logic                 bootFetch,
  output logic [AW-1:0]        bootVecLo,
  output logic [AW-1:0]        bootVecHi,
  output logic [NUM_OSC-1:0]   oscEn,
  output logic                 padAPullEn,
  output logic                 padBDriveLow,
  output logic [NUM_PADS-1:0]  otherPadOe,
  output logic [NUM_CAUSE-1:0] causes
);

  localparam int FILT_CYC = REF_CLK_KHZ * 10 / 1000;

  hubStrobe_t strobe;
  logic       coreRstN;

  reset_hub_ctrl #(.FILT_CYC(FILT_CYC), .STRETCH(STRETCH)) u_ctrl (
    .clk           (clk),
    .porDet        (porDet),
    .extRstN       (extRstN),
    .wdtOvf        (wdtOvf),
    .lvdDet        (lvdDet),
    .ramParityErr  (ramParityErr),
    .illegalAccess (illegalAccess),
    .opcodeValid   (opcodeValid),
    .opcodeByte    (opcodeByte),
    .debugMode     (debugMode),
    .coreRstN      (coreRstN),
    .sysRstN       (sysRstN),
    .bootFetch     (bootFetch),
    .strobe        (strobe)
  );

  reset_hub_dp #(.NUM_OSC(NUM_OSC)) u_dp (
    .clk            (clk),
    .coreRstN       (coreRstN),
    .causeReadClear (causeReadClear),
    .strobe         (strobe),
    .oscEn          (oscEn),
    .padAPullEn     (padAPullEn),
    .causes         (causes)
  );

  assign bootVecLo    = AW'(VEC_LO_ADDR);
  assign bootVecHi    = AW'(VEC_LO_ADDR + 1);
  assign padBDriveLow = 1'b1;
  assign otherPadOe   = '0;

endmodule

// File: rtl/reset_hub_chk.sv
module reset_hub_chk #(
  parameter int NUM_OSC = 4
) (
  input logic               clk,
  input logic               porDet,
  input logic               debugMode,
  input logic               sysRstN,
  input logic               bootFetch,
  input logic [NUM_OSC-1:0] oscEn,
  input logic               padAPullEn,
  input logic [4:0]         causes
);

  assert_osc_off_R7: assert property (@(posedge clk) disable iff (porDet)
    !sysRstN |-> (oscEn == '0));

  assert_osc_on_R7: assert property (@(posedge clk) disable iff (porDet)
    sysRstN |-> (&oscEn));

  assert_boot_at_release_R6: assert property (@(posedge clk) disable iff (porDet)
    bootFetch |-> $rose(sysRstN));

  assert_boot_single_R6: assert property (@(posedge clk) disable iff (porDet)
    bootFetch |=> !bootFetch);

  assert_hiz_only_in_reset_R8: assert property (@(posedge clk) disable iff (porDet)
    !padAPullEn |-> !sysRstN);

  assert_debug_blocks_opc_R4: assert property (@(posedge clk) disable iff (porDet)
    $past(debugMode) |=> !$rose(causes[2]));

endmodule

bind reset_hub reset_hub_chk #(.NUM_OSC(NUM_OSC)) u_chk (
  .clk        (clk),
  .porDet     (porDet),
  .debugMode  (debugMode),
  .sysRstN    (sysRstN),
  .bootFetch  (bootFetch),
  .oscEn      (oscEn),
  .padAPullEn (padAPullEn),
  .causes     (causes)
);

// File: tb/tb_reset_hub.sv
module tb_reset_hub;

  localparam int CLK_PERIOD = 10;
  localparam int KHZ        = 1600;
  localparam int FILT       = KHZ * 10 / 1000;
  localparam int STR        = 8;
  localparam int NOSC       = 4;
  localparam int NPADS      = 8;

  logic clk = 1'b0;
  logic porDet = 1'b1, extRstN = 1'b1, wdtOvf = 1'b0, lvdDet = 1'b0;
  logic ramParityErr = 1'b0, illegalAccess = 1'b0, opcodeValid = 1'b0;
  logic [7:0] opcodeByte = 8'h00;
  logic debugMode = 1'b0, causeReadClear = 1'b0;
  logic sysRstN, bootFetch, padAPullEn, padBDriveLow;
  logic [15:0] bootVecLo, bootVecHi;
  logic [NOSC-1:0] oscEn;
  logic [NPADS-1:0] otherPadOe;
  logic [4:0] causes;

  reset_hub #(.REF_CLK_KHZ(KHZ), .STRETCH(STR), .NUM_OSC(NOSC), .NUM_PADS(NPADS)) dut (
    .clk(clk), .porDet(porDet), .extRstN(extRstN), .wdtOvf(wdtOvf), .lvdDet(lvdDet),
    .ramParityErr(ramParityErr), .illegalAccess(illegalAccess), .opcodeValid(opcodeValid),
    .opcodeByte(opcodeByte), .debugMode(debugMode), .causeReadClear(causeReadClear),
    .sysRstN(sysRstN), .bootFetch(bootFetch), .bootVecLo(bootVecLo), .bootVecHi(bootVecHi),
    .oscEn(oscEn), .padAPullEn(padAPullEn), .padBDriveLow(padBDriveLow),
    .otherPadOe(otherPadOe), .causes(causes)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFail = 0, cyc = 0;
  int lowCycles = 0, bootCnt = 0, oscBad = 0;
  logic hizSeen = 1'b0;
  logic done = 1'b0;
  logic [4:0] model = '0;

  always @(negedge clk) begin
    if (!sysRstN) lowCycles++;
    if (bootFetch) bootCnt++;
    if (!padAPullEn) hizSeen = 1'b1;
    if (!sysRstN && oscEn != '0) oscBad++;
    if (sysRstN && oscEn != '1) oscBad++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nFail++;
      $display("FAIL watchdog R5: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int expLow(input int reqEdges);
    return reqEdges + STR - 1;
  endfunction

  task automatic clearMon();
    lowCycles = 0; bootCnt = 0; oscBad = 0; hizSeen = 1'b0;
  endtask

  // kind: 0 ext pin, 1 wdt, 2 lvd, 3 opcode, 4 parity, 5 access, 6 read-clear
  task automatic runTrial(input int kind, input int len, input logic [7:0] opc, input logic dbg);
    int lowExp = 0, bootExp = 0, hizExp = 0;
    string tag = "R1";
    clearMon();
    case (kind)
      0: begin
        tag = "R2";
        extRstN = 1'b0; tick(len); extRstN = 1'b1;
        if (len >= FILT) begin
          model = '0; lowExp = len - FILT + STR; bootExp = 1; hizExp = 1;
        end
      end
      1, 2, 4, 5: begin
        case (kind)
          1: wdtOvf = 1'b1;
          2: lvdDet = 1'b1;
          4: ramParityErr = 1'b1;
          default: illegalAccess = 1'b1;
        endcase
        tick(3);
        wdtOvf = 1'b0; lvdDet = 1'b0; ramParityErr = 1'b0; illegalAccess = 1'b0;
        model[kind == 1 ? 0 : kind == 2 ? 1 : kind == 4 ? 3 : 4] = 1'b1;
        lowExp = expLow(3); bootExp = 1;
      end
      3: begin
        tag = dbg ? "R4" : "R3";
        opcodeValid = 1'b1; opcodeByte = opc; debugMode = dbg;
        tick(1);
        opcodeValid = 1'b0; tick(1); debugMode = 1'b0;
        if (opc == 8'hFF && !dbg) begin
          model[2] = 1'b1; lowExp = expLow(1); bootExp = 1;
        end
      end
      default: begin
        tag = "R10";
        causeReadClear = 1'b1; tick(1); causeReadClear = 1'b0;
        model = '0;
      end
    endcase
    tick(2 * FILT + STR + 12);
    chk({tag, " low time R5"}, lowCycles, lowExp);
    chk({tag, " boot pulses R6"}, bootCnt, bootExp);
    chk({tag, " pad A hi-Z seen R8"}, int'(hizSeen), hizExp);
    chk({tag, " causes R10"}, int'(causes), int'(model));
    chk({tag, " osc enables R7"}, oscBad, 0);
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'd20240611);
    // power-on state
    tick(4);
    chk("POR sysRstN R11", int'(sysRstN), 0);
    chk("POR oscEn R7", int'(oscEn), 0);
    chk("POR pad A hi-Z R8", int'(padAPullEn), 0);
    chk("POR causes R11", int'(causes), 0);
    clearMon();
    porDet = 1'b0;
    tick(STR + 10);
    chk("POR release R6", int'(sysRstN), 1);
    chk("POR single boot R6", bootCnt, 1);
    chk("vector low R6", int'(bootVecLo), 0);
    chk("vector high R6", int'(bootVecHi), 1);
    chk("osc on R7", int'(oscEn), (1 << NOSC) - 1);
    chk("pad A pulled R8", int'(padAPullEn), 1);
    chk("pad B low R9", int'(padBDriveLow), 1);
    chk("other pads hi-Z R9", int'(otherPadOe), 0);

    // directed corners
    runTrial(1, 0, 8'h00, 1'b0);       // watchdog R1
    runTrial(0, FILT - 1, 8'h00, 1'b0); // just short R2
    runTrial(0, FILT, 8'h00, 1'b0);     // just long R2, clears causes R11
    runTrial(4, 0, 8'h00, 1'b0);
    runTrial(3, 0, 8'hFF, 1'b1);        // debug suppresses R4
    runTrial(3, 0, 8'hFE, 1'b0);        // other byte R3
    runTrial(3, 0, 8'hFF, 1'b0);        // illegal opcode R3
    runTrial(5, 0, 8'h00, 1'b0);
    runTrial(2, 0, 8'h00, 1'b0);
    runTrial(6, 0, 8'h00, 1'b0);        // read-clear R10

    // power-on in mid-run with causes set
    runTrial(1, 0, 8'h00, 1'b0);
    porDet = 1'b1; tick(1);
    chk("mid POR causes R11", int'(causes), 0);
    chk("mid POR sysRstN R11", int'(sysRstN), 0);
    porDet = 1'b0; model = '0;
    tick(STR + 10);
    chk("mid POR release R5", int'(sysRstN), 1);

    // constrained random
    for (int t = 0; t < 60; t++) begin
      int kind = int'($urandom % 7);
      int len = 1 + int'($urandom % (2 * FILT));
      logic [7:0] opc = ($urandom % 3 == 0) ? 8'($urandom % 255) : 8'hFF;
      logic dbg = ($urandom % 3 == 0);
      runTrial(kind, len, opc, dbg);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule